// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single down-counting timer that a processor programs through a small word-addressed register port. Software chooses a reload value and a counting mode, then enables the timer. On each prescaled tick the counter steps down by one. Each time it expires it raises a level interrupt, which stays up until software clears it. The counter can run in a free-running mode, in a periodic mode or in a one-shot mode. It can be 16 or 32 bits wide. A prescaler divides the incoming tick strobe by 1, 16 or 256.

The reload value can be written in two ways. One write also reloads the live count at once. The other replaces only the value used at the next reload, so the period can be changed without disturbing the interval in progress. The raw interrupt flag and the flag gated by the interrupt enable can both be read. The `tick_in` strobe is a one-cycle enable in the `clk` domain. The register port is a single-cycle write with a combinational read of the addressed word.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word reads 0x20, with only the interrupt enable set. The load value and the live count read 0, and `irq` is low.
- R2: A write to offset 0 sets the reload value and loads the live count in the same cycle. A write to offset 6 sets only the reload value and leaves the count unchanged. A read of offset 0 or offset 6 returns the reload value.
- R3: Control bits [3:2] select the prescale. Value 1 steps the counter every 16th tick and value 2 every 256th tick; values 0 and 3 step it on every tick. The counter moves only while control bit 7 (enable) is set. The prescale phase restarts whenever the control word is written or the timer is disabled.
- R4: A step that finds the count at 1 or 0 is an expiry. It sets the raw interrupt flag. In periodic mode (bit 6 set, bit 0 clear) the count reloads from the reload value. In free-running mode (bits 6 and 0 clear) it reloads from all ones of the selected width, and a write to offset 0 also loads all ones in this mode.
- R5: In one-shot mode (bit 0 set, which takes precedence over bit 6), an expiry leaves the count at 0 and clears control bit 7.
- R6: When control bit 1 is clear, only the low 16 bits of the reload value and of the count take part. Offset 1 then reads with bits [31:16] at zero.
- R7: Offset 4 bit 0 reads the raw flag. Offset 5 bit 0 reads the raw flag ANDed with control bit 5, which is the interrupt enable. `irq` follows that same AND.
- R8: Any write to offset 3 clears the raw flag. If an expiry happens in the same cycle, the flag is set.
- R9: Writes to offset 1 leave the count unchanged. Reads of offsets 3 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle tick strobe that feeds the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: raw flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: a 32-bit counter with a 16-bit narrow mode, and prescale shifts of 4 and 8. With the full 256 division, a one-shot interval of three steps completes in under a thousand cycles, so the one-shot stop and the enable self-clear are covered. With the 16-bit width, the free-running reload to 0xFFFF can be seen after a short count, without waiting for a full wrap.

// File: rtl/itmr_pkg.sv
// Shared definitions for the interval timer: register offsets and the
// control word layout. Assumes a 3-bit word offset on the register port.
package itmr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_LOAD   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_VALUE  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_BGLOAD = 3'd6;

    localparam int CTRL_W = 8;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

    // Control fields, stored apart from their bus positions.
    typedef struct packed {
        logic       run;      // bit 7
        logic       repeat_m; // bit 6
        logic       irq_en;   // bit 5
        logic [1:0] pre_sel;  // bits 3:2
        logic       wide;     // bit 1
        logic       single;   // bit 0
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] b);
        ctrl_t c;
        c.run      = b[7];
        c.repeat_m = b[6];
        c.irq_en   = b[5];
        c.pre_sel  = b[3:2];
        c.wide     = b[1];
        c.single   = b[0];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        return {c.run, c.repeat_m, c.irq_en, 1'b0, c.pre_sel, c.wide, c.single};
    endfunction

endpackage

// File: rtl/itmr_prescaler.sv
// Tick prescaler. Counts tick_in strobes and emits a one-cycle step when
// the selected number of low bits of its phase counter are all ones.
// Assumes LOG_MID < LOG_HI; select values 0 and 3 pass every tick.
module itmr_prescaler #(
    parameter int LOG_MID = 4,
    parameter int LOG_HI  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic       tick_in,
    input  logic [1:0] sel,
    output logic       step
);
    localparam logic [LOG_HI-1:0] MID_MASK = LOG_HI'((1 << LOG_MID) - 1);
    localparam logic [LOG_HI-1:0] HI_MASK  = {LOG_HI{1'b1}};

    logic [LOG_HI-1:0] phase_q;
    logic [LOG_HI-1:0] mask;

    // Pick the phase bits that must be all ones for a step.
    always_comb begin
        unique case (sel)
            2'd1:    mask = MID_MASK;
            2'd2:    mask = HI_MASK;
            default: mask = '0;
        endcase
    end

    assign step = run && tick_in && ((phase_q & mask) == mask);

    // Advance the phase on each tick; restart while stopped or on reprogram.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            phase_q <= '0;
        end else if (tick_in) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_counter.sv
// Down-counter with mode-dependent reload. Narrow mode keeps only the low
// NARROW_W bits in play. Expiry is a step that finds the count at 1 or 0.
// Assumes NARROW_W < DATA_W.
module itmr_counter #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load_now,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] limit_q,
    input  logic              wide,
    input  logic              repeat_m,
    input  logic              single,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] count_view,
    output logic              expire
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic freerun;
    logic [DATA_W-1:0] load_fit;
    logic [DATA_W-1:0] reload_fit;

    // Trim a value to the active width.
    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v,
                                              input logic w);
        return w ? v : (v & NARROW_MASK);
    endfunction

    // Decode mode and the values the counter may take next.
    always_comb begin
        freerun    = !repeat_m && !single;
        count_view = fit(count_q, wide);
        load_fit   = freerun ? fit('1, wide) : fit(load_val, wide);
        reload_fit = freerun ? fit('1, wide) : fit(limit_q, wide);
        expire     = step && (count_view <= ONE);
    end

    // Load, reload, hold at zero or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_now) begin
            count_q <= load_fit;
        end else if (expire) begin
            count_q <= single ? '0 : reload_fit;
        end else if (step) begin
            count_q <= count_view - ONE;
        end
    end
endmodule

// File: rtl/itmr_regs.sv
// Register file: control word, reload value and raw interrupt flag.
// Assumes single-cycle writes; an expiry outranks a clear in the same cycle.
module itmr_regs #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [itmr_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      expire,
    output itmr_pkg::ctrl_t           ctrl_q,
    output logic [DATA_W-1:0]         limit_q,
    output logic                      raw_q
);
    import itmr_pkg::*;

    logic wr_ctrl, wr_limit, wr_clear;

    // Decode the writes.
    always_comb begin
        wr_ctrl  = wr_en && (addr == OFF_CTRL);
        wr_limit = wr_en && ((addr == OFF_LOAD) || (addr == OFF_BGLOAD));
        wr_clear = wr_en && (addr == OFF_ICLR);
    end

    // Control word; a one-shot expiry drops the run bit unless rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_unpack(CTRL_RESET);
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_unpack(wdata[CTRL_W-1:0]);
        end else if (expire && ctrl_q.single) begin
            ctrl_q.run <= 1'b0;
        end
    end

    // Reload value, shared by both load offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (wr_limit) begin
            limit_q <= wdata;
        end
    end

    // Raw interrupt flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (expire) begin
            raw_q <= 1'b1;
        end else if (wr_clear) begin
            raw_q <= 1'b0;
        end
    end
endmodule

// File: rtl/itmr_readmux.sv
// Read data selection for the register port. Purely combinational;
// unmapped and write-only offsets read as zero.
module itmr_readmux #(
    parameter int DATA_W = 32
) (
    input  logic [itmr_pkg::ADDR_W-1:0] addr,
    input  itmr_pkg::ctrl_t           ctrl_q,
    input  logic [DATA_W-1:0]         limit_q,
    input  logic [DATA_W-1:0]         count_view,
    input  logic                      raw_q,
    output logic [DATA_W-1:0]         rdata
);
    import itmr_pkg::*;

    // Select the addressed word.
    always_comb begin
        unique case (addr)
            OFF_LOAD, OFF_BGLOAD: rdata = limit_q;
            OFF_VALUE:            rdata = count_view;
            OFF_CTRL:             rdata = DATA_W'(ctrl_pack(ctrl_q));
            OFF_RAW:              rdata = DATA_W'(raw_q);
            OFF_MASKED:           rdata = DATA_W'(raw_q && ctrl_q.irq_en);
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/interval_timer.sv
// Top of the programmable interval timer: register file, prescaler,
// counter and read mux. Assumes tick_in is a one-cycle strobe in clk.
module interval_timer #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int PRE_MID  = 4,
    parameter int PRE_HI   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    import itmr_pkg::*;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] limit_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] count_view;
    logic              raw_q;
    logic              step;
    logic              expire;
    logic              load_now;
    logic              ctrl_wr;
    logic [CTRL_W-1:0] ctrl_bits;

    // Write decodes that cross sub-blocks.
    always_comb begin
        load_now  = wr_en && (addr == OFF_LOAD);
        ctrl_wr   = wr_en && (addr == OFF_CTRL);
        ctrl_bits = ctrl_pack(ctrl_q);
    end

    itmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .expire  (expire),
        .ctrl_q  (ctrl_q),
        .limit_q (limit_q),
        .raw_q   (raw_q)
    );

    itmr_prescaler #(.LOG_MID(PRE_MID), .LOG_HI(PRE_HI)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .restart (ctrl_wr),
        .tick_in (tick_in),
        .sel     (ctrl_q.pre_sel),
        .step    (step)
    );

    itmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_now   (load_now),
        .load_val   (wdata),
        .limit_q    (limit_q),
        .wide       (ctrl_q.wide),
        .repeat_m   (ctrl_q.repeat_m),
        .single     (ctrl_q.single),
        .count_q    (count_q),
        .count_view (count_view),
        .expire     (expire)
    );

    itmr_readmux #(.DATA_W(DATA_W)) u_rd (
        .addr       (addr),
        .ctrl_q     (ctrl_q),
        .limit_q    (limit_q),
        .count_view (count_view),
        .raw_q      (raw_q),
        .rdata      (rdata)
    );

    // Interrupt line: raw flag gated by the enable.
    always_comb irq = raw_q && ctrl_q.irq_en;
endmodule

// File: rtl/itmr_checker.sv
// Property checker for the interval timer, attached by bind.
module itmr_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [7:0]        ctrl_bits,
    input logic [DATA_W-1:0] limit_q,
    input logic [DATA_W-1:0] count_q,
    input logic              raw_q,
    input logic              step,
    input logic              expire
);
    AST_RESET_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_bits == 8'h20));  // R1
    AST_LOAD_SETS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> (limit_q == $past(wdata)));  // R2
    AST_BGLOAD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd6 && !step) |=> $stable(count_q));  // R2
    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[7] && !(wr_en && addr == 3'd0)) |=> $stable(count_q));  // R3
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_bits[0] && !(wr_en && (addr == 3'd2 || addr == 3'd0)))
        |=> (!ctrl_bits[7] && count_q == '0));  // R5
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[1] && addr == 3'd1) |-> (rdata[DATA_W-1:16] == '0));  // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_bits[5]);  // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_q);  // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3 && !expire) |=> !raw_q);  // R8
    AST_VALUE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && !step) |=> $stable(count_q));  // R9
endmodule

bind interval_timer itmr_checker #(.DATA_W(DATA_W)) u_itmr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq),
    .ctrl_bits (ctrl_bits),
    .limit_q   (limit_q),
    .count_q   (count_q),
    .raw_q     (raw_q),
    .step      (step),
    .expire    (expire)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
// Bench: behavioural model of the timer updated each clock, compared with
// rdata and irq after every input change, plus fixed-value checks.
module interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Model state
    logic [31:0] m_ctrl, m_limit, m_cnt;
    logic        m_raw;
    int          m_pc;

    function automatic logic [31:0] m_fit(input logic [31:0] v);
        return m_ctrl[1] ? v : (v & 32'h0000_FFFF);
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd6: return m_limit;
            3'd1:       return m_fit(m_cnt);
            3'd2:       return m_ctrl;
            3'd4:       return {31'd0, m_raw};
            3'd5:       return {31'd0, m_raw & m_ctrl[5]};
            default:    return 32'd0;
        endcase
    endfunction

    // Model update at each clock edge.
    always @(posedge clk) begin : model
        int div;
        logic stp, exp_e, free_m;
        logic [31:0] cur, nc;
        if (!rst_n) begin
            m_ctrl = 32'h20; m_limit = 0; m_cnt = 0; m_raw = 0; m_pc = 0;
        end else begin
            div    = (m_ctrl[3:2] == 2'd1) ? 16 : (m_ctrl[3:2] == 2'd2) ? 256 : 1;
            stp    = m_ctrl[7] && tick_in && ((m_pc % div) == div - 1);
            cur    = m_fit(m_cnt);
            exp_e  = stp && (cur <= 1);
            free_m = !m_ctrl[0] && !m_ctrl[6];
            nc     = m_cnt;
            if (wr_en && addr == 3'd0)
                nc = free_m ? m_fit(32'hFFFF_FFFF) : m_fit(wdata);
            else if (exp_e)
                nc = m_ctrl[0] ? 32'd0 : (free_m ? m_fit(32'hFFFF_FFFF) : m_fit(m_limit));
            else if (stp)
                nc = cur - 1;
            if (!m_ctrl[7] || (wr_en && addr == 3'd2)) m_pc = 0;
            else if (tick_in) m_pc = (m_pc + 1) % 256;
            if (exp_e) m_raw = 1'b1;
            else if (wr_en && addr == 3'd3) m_raw = 1'b0;
            if (wr_en && (addr == 3'd0 || addr == 3'd6)) m_limit = wdata;
            if (wr_en && addr == 3'd2) m_ctrl = wdata & 32'h0000_00EF;
            else if (exp_e && m_ctrl[0]) m_ctrl[7] = 1'b0;
            m_cnt = nc;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp_v, $time);
        end
    endtask

    // One clock: drive inputs at the falling edge, compare with the model.
    task automatic cyc(input string tag, input logic w, input logic [2:0] a,
                       input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tick_in = t;
        #1;
        chk(tag, rdata, m_read(a));
        chk(tag, {31'd0, irq}, {31'd0, m_raw & m_ctrl[5]});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc("R1", 0, 3'd2, 0, 0); chk("R1", rdata, 32'h20);
        cyc("R1", 0, 3'd1, 0, 0); chk("R1", rdata, 32'h0);
        cyc("R1", 0, 3'd0, 0, 0); chk("R1", rdata, 32'h0);
        chk("R1", {31'd0, irq}, 32'd0);

        // R2 immediate and background load
        cyc("R2", 1, 3'd2, 32'h62, 0);
        cyc("R2", 1, 3'd0, 32'd5, 0);
        cyc("R2", 0, 3'd1, 0, 0); chk("R2", rdata, 32'd5);
        cyc("R2", 1, 3'd6, 32'd9, 0);
        cyc("R2", 0, 3'd1, 0, 0); chk("R2", rdata, 32'd5);
        cyc("R2", 0, 3'd0, 0, 0); chk("R2", rdata, 32'd9);
        cyc("R2", 0, 3'd6, 0, 0); chk("R2", rdata, 32'd9);

        // R4 periodic counting and reload; R7 status
        cyc("R4", 1, 3'd2, 32'hE2, 0);
        for (int i = 0; i < 25; i++) cyc("R4", 0, 3'd1, 0, 1);
        cyc("R7", 0, 3'd4, 0, 0); chk("R7", rdata, 32'd1);
        chk("R7", {31'd0, irq}, 32'd1);
        cyc("R7", 0, 3'd5, 0, 0); chk("R7", rdata, 32'd1);

        // R8 clear, then clear racing an expiry
        cyc("R8", 1, 3'd3, 0, 0);
        cyc("R8", 0, 3'd4, 0, 0); chk("R8", rdata, 32'd0);
        for (int i = 0; i < 30; i++) cyc("R8", 1, 3'd3, 0, 1);
        cyc("R8", 1, 3'd3, 0, 0);

        // R7 masking with interrupt enable off
        cyc("R7", 1, 3'd2, 32'hC2, 0);
        for (int i = 0; i < 12; i++) cyc("R7", 0, 3'd5, 0, 1);
        cyc("R7", 0, 3'd4, 0, 0); chk("R7", rdata, 32'd1);
        cyc("R7", 0, 3'd5, 0, 0); chk("R7", rdata, 32'd0);
        chk("R7", {31'd0, irq}, 32'd0);

        // R3 prescale 16 with gaps, select 3, and disabled hold
        cyc("R3", 1, 3'd3, 0, 0);
        cyc("R3", 1, 3'd2, 32'hE6, 0);
        cyc("R3", 1, 3'd0, 32'd4, 0);
        for (int i = 0; i < 200; i++) cyc("R3", 0, 3'd1, 0, (i % 3) != 0);
        cyc("R3", 1, 3'd2, 32'hEE, 0);
        for (int i = 0; i < 30; i++) cyc("R3", 0, 3'd1, 0, 1);
        cyc("R3", 1, 3'd2, 32'h66, 0);
        cyc("R3", 1, 3'd0, 32'd7, 0);
        for (int i = 0; i < 40; i++) cyc("R3", 0, 3'd1, 0, 1);
        chk("R3", rdata, 32'd7);

        // R5 one-shot at prescale 256
        cyc("R5", 1, 3'd3, 0, 0);
        cyc("R5", 1, 3'd2, 32'h2B, 0);
        cyc("R5", 1, 3'd0, 32'd3, 0);
        cyc("R5", 1, 3'd2, 32'hAB, 0);
        for (int i = 0; i < 800; i++) cyc("R5", 0, 3'd1, 0, 1);
        chk("R5", rdata, 32'd0);
        cyc("R5", 0, 3'd2, 0, 1); chk("R5", rdata, 32'h2B);
        chk("R5", {31'd0, irq}, 32'd1);

        // R6 narrow width
        cyc("R6", 1, 3'd3, 0, 0);
        cyc("R6", 1, 3'd2, 32'h60, 0);
        cyc("R6", 1, 3'd0, 32'h1234_0003, 0);
        cyc("R6", 0, 3'd1, 0, 0); chk("R6", rdata, 32'h0000_0003);
        cyc("R6", 0, 3'd0, 0, 0); chk("R6", rdata, 32'h1234_0003);
        cyc("R6", 1, 3'd2, 32'hE0, 0);
        for (int i = 0; i < 20; i++) cyc("R6", 0, 3'd1, 0, 1);

        // R4 free-running reload to all ones
        cyc("R4", 1, 3'd2, 32'h60, 0);
        cyc("R4", 1, 3'd0, 32'd5, 0);
        cyc("R4", 1, 3'd2, 32'hA0, 0);
        for (int i = 0; i < 8; i++) cyc("R4", 0, 3'd1, 0, 1);
        cyc("R4", 0, 3'd1, 0, 0); chk("R4", rdata, 32'h0000_FFFC);
        cyc("R4", 1, 3'd2, 32'h22, 0);
        cyc("R4", 1, 3'd0, 32'd10, 0);
        cyc("R4", 0, 3'd1, 0, 0); chk("R4", rdata, 32'hFFFF_FFFF);

        // R9 value write ignored; write-only and unmapped offsets read 0
        cyc("R9", 1, 3'd1, 32'hDEAD_BEEF, 0);
        cyc("R9", 0, 3'd1, 0, 0); chk("R9", rdata, 32'hFFFF_FFFF);
        cyc("R9", 0, 3'd3, 0, 0); chk("R9", rdata, 32'd0);
        cyc("R9", 0, 3'd7, 0, 0); chk("R9", rdata, 32'd0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule